// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This control unit moves a small 32-bit core into supervisor state and back out again. It handles four kinds of event. Reset always wins. Internal faults arrive as a kind code, with a trap index for traps. External interrupts arrive as a level. The core also asks for a return-from-exception.

For a fault or an accepted interrupt, the unit works out an 8-bit vector number. For a fault it decodes the number itself. For an interrupt it runs an acknowledge handshake with the interrupt controller and takes the number that comes back. It then writes a two-longword frame onto the system stack, reads the handler pointer from `vbr + 4*vector` and loads it into the program counter. A return reads the frame back. It restores the status register and program counter and puts the stack pointer back exactly where it was before entry, including any misalignment. After reset the unit reads its initial stack pointer and program counter from memory.

All memory traffic goes through one port that carries a single outstanding request and waits on a ready handshake. The status register, stack pointer, program counter and vector base are registered outputs. Status-register bits: 15 = trace, 13 = supervisor, 12 = master, 10:8 = interrupt mask.

Top module: `exc_seq`

## Requirements
- R1: A synchronous reset sets the status register to 0x2700 and the vector base to 0. The unit then reads the word at address 0 into the stack pointer and the word at address 4 into the program counter, and pulses `done` when the second read completes.
- R2: Reset aborts any entry or return in progress and restarts the start-up sequence of R1.
- R3: On entry the unit clears trace (bit 15) and master (bit 12) and sets supervisor (bit 13). For a fault the mask is left unchanged. Fault kind codes select the vector: 0 gives 2, 1 gives 4, 2 gives 5, 3 gives 8, and 4 gives 32 plus the trap index. Codes 5 to 7 give 4.
- R4: An interrupt is accepted only when its level is strictly greater than the current mask. An accepted interrupt loads the mask with its level, runs an acknowledge handshake, and uses the returned byte as the vector.
- R5: The frame base is the stack pointer rounded down to a multiple of 4, minus 8. The return PC goes to base+4 and the frame word goes to base. The stack pointer becomes base.
- R6: Frame word layout: bits 31:28 hold 4 plus the two low bits of the incoming stack pointer, bits 25:18 hold the vector, bits 15:0 hold the status register from before entry, and all other bits are 0.
- R7: After pushing, the unit reads the longword at `vbr + 4*vector` into the program counter and pulses `done` for one cycle.
- R8: A return in supervisor state reads the word at SP and loads its bits 15:0 into the status register. It reads the word at SP+4 into the program counter. The stack pointer becomes SP + 8 + frame-word bits 29:28.
- R9: A return requested in user state (bit 13 clear) is taken as a privilege violation: vector 8, with `ret_pc` pushed.
- R10: A fault outranks an interrupt, and an interrupt outranks a return. Requests are sampled only while idle, and a request held during a sequence does not start a second one.
- R11: A memory request keeps its address, direction and data stable until `mem_rdy`, and every address is a multiple of 4.
- R12: A vector-base write takes effect with bits 1:0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_req | input | 1 | Internal fault request (level) |
| fault_kind | input | 3 | Fault kind code |
| trap_idx | input | 4 | Trap index for kind 4 |
| irq_req | input | 1 | Interrupt request |
| irq_lvl | input | 3 | Interrupt level |
| rte_req | input | 1 | Return-from-exception request |
| ret_pc | input | 32 | PC to save in the frame |
| iack_req | output | 1 | Interrupt acknowledge request |
| iack_lvl | output | 3 | Level being acknowledged |
| iack_ack | input | 1 | Controller answers acknowledge |
| iack_vec | input | 8 | Vector from controller |
| vbr_wr_en | input | 1 | Vector-base write strobe |
| vbr_wr_data | input | 32 | Vector-base write value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_rdy | input | 1 | Memory handshake |
| sr_o | output | 16 | Status register |
| sp_o | output | 32 | System stack pointer |
| pc_o | output | 32 | Program counter |
| vbr_o | output | 32 | Vector base |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | PC valid pulse |

## Verification
The bench goes after several corner cases, each of which shows a specific fault:
- **Misaligned stack pointer at reset.** If the format nibble were wrong or missing, the return would land a few bytes off the original pointer.
- **Return in user state.** A unit that ignored privilege would pop a frame instead of entering on vector 8.
- **Interrupt level equal to the mask.** A `>=` comparison would take it.
- **Fault and interrupt raised together.** The wrong vector would appear in the frame.
- **Fault request held through a whole sequence.** The unit would push a second frame.
- **Reset mid-frame.** Without the abort, the stale sequence would finish instead of the start-up reads.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [3:0] {
    ST_BOOT_SP,
    ST_BOOT_PC,
    ST_IDLE,
    ST_IACK,
    ST_PUSH_PC,
    ST_PUSH_SR,
    ST_FETCH,
    ST_RTE_SR,
    ST_RTE_PC
  } exc_state_e;

  localparam int SR_W       = 16;
  localparam int SR_TRACE   = 15;
  localparam int SR_SUPER   = 13;
  localparam int SR_MASTER  = 12;
  localparam int MASK_LO    = 8;
  localparam int IPL_W      = 3;

  localparam logic [SR_W-1:0] SR_RESET = 16'h2700;

  localparam logic [7:0] VEC_ACCESS  = 8'd2;
  localparam logic [7:0] VEC_ILLEGAL = 8'd4;
  localparam logic [7:0] VEC_DIVZ    = 8'd5;
  localparam logic [7:0] VEC_PRIV    = 8'd8;
  localparam logic [7:0] VEC_TRAP0   = 8'd32;

  // status register as seen inside a handler: supervisor on, trace and
  // master off, mask replaced
  function automatic logic [SR_W-1:0] entry_sr(input logic [SR_W-1:0] sr,
                                               input logic [IPL_W-1:0] mask);
    logic [SR_W-1:0] r;
    r = sr;
    r[SR_TRACE]  = 1'b0;
    r[SR_SUPER]  = 1'b1;
    r[SR_MASTER] = 1'b0;
    r[MASK_LO +: IPL_W] = mask;
    return r;
  endfunction

endpackage

// File: rtl/exc_vec.sv
module exc_vec
  import exc_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int KIND_W = 3,
  parameter int TRAP_W = 4
) (
  input  logic [KIND_W-1:0] fault_kind,
  input  logic [TRAP_W-1:0] trap_idx,
  input  logic              irq_req,
  input  logic [IPL_W-1:0]  irq_lvl,
  input  logic [IPL_W-1:0]  cur_mask,
  output logic [VEC_W-1:0]  fault_vec,
  output logic              irq_take
);

  always_comb begin
    case (fault_kind)
      KIND_W'(0): fault_vec = VEC_W'(VEC_ACCESS);
      KIND_W'(1): fault_vec = VEC_W'(VEC_ILLEGAL);
      KIND_W'(2): fault_vec = VEC_W'(VEC_DIVZ);
      KIND_W'(3): fault_vec = VEC_W'(VEC_PRIV);
      KIND_W'(4): fault_vec = VEC_W'(VEC_TRAP0) + VEC_W'(trap_idx);
      default:    fault_vec = VEC_W'(VEC_ILLEGAL);
    endcase
  end

  // strict comparison: a level equal to the mask stays pending
  assign irq_take = irq_req && (irq_lvl > cur_mask);

endmodule

// File: rtl/exc_frame.sv
module exc_frame
  import exc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic [ADDR_W-1:0] sp,
  input  logic [SR_W-1:0]   sr_keep,
  input  logic [VEC_W-1:0]  vec,
  input  logic [1:0]        pop_adj,
  output logic [ADDR_W-1:0] frame_base,
  output logic [DATA_W-1:0] frame_word,
  output logic [ADDR_W-1:0] sp_restore
);

  localparam int FMT_LO  = DATA_W - 4;
  localparam int VEC_LO  = 18;
  localparam logic [3:0] FMT_BIAS = 4'd4;
  localparam logic [ADDR_W-1:0] FRAME_BYTES = ADDR_W'(8);

  assign frame_base = {sp[ADDR_W-1:2], 2'b00} - FRAME_BYTES;

  always_comb begin
    frame_word = '0;
    frame_word[FMT_LO +: 4]    = FMT_BIAS + {2'b00, sp[1:0]};
    frame_word[VEC_LO +: VEC_W] = vec;
    frame_word[0 +: SR_W]      = sr_keep;
  end

  assign sp_restore = sp + FRAME_BYTES + ADDR_W'(pop_adj);

endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8,
  parameter int KIND_W = 3,
  parameter int TRAP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fault_req,
  input  logic [KIND_W-1:0] fault_kind,
  input  logic [TRAP_W-1:0] trap_idx,
  input  logic              irq_req,
  input  logic [2:0]        irq_lvl,
  input  logic              rte_req,
  input  logic [31:0]       ret_pc,
  output logic              iack_req,
  output logic [2:0]        iack_lvl,
  input  logic              iack_ack,
  input  logic [VEC_W-1:0]  iack_vec,
  input  logic              vbr_wr_en,
  input  logic [ADDR_W-1:0] vbr_wr_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rdy,
  output logic [15:0]       sr_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic [31:0]       pc_o,
  output logic [ADDR_W-1:0] vbr_o,
  output logic              busy,
  output logic              done
);

  localparam int FMT_LO = DATA_W - 4;
  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(4);

  exc_state_e        state;
  logic [VEC_W-1:0]  vec_r;
  logic [SR_W-1:0]   sr_copy;
  logic [31:0]       pc_save;
  logic [SR_W-1:0]   pop_sr;
  logic [1:0]        pop_adj;

  logic [VEC_W-1:0]  fault_vec;
  logic              irq_take;
  logic [ADDR_W-1:0] frame_base;
  logic [DATA_W-1:0] frame_word;
  logic [ADDR_W-1:0] sp_restore;

  logic              go_entry;
  logic              go_irq;
  logic              go_pop;
  logic [VEC_W-1:0]  entry_vec;
  logic [IPL_W-1:0]  cur_mask;

  assign cur_mask = sr_o[MASK_LO +: IPL_W];

  exc_vec #(.VEC_W(VEC_W), .KIND_W(KIND_W), .TRAP_W(TRAP_W)) vec_i (
    .fault_kind (fault_kind),
    .trap_idx   (trap_idx),
    .irq_req    (irq_req),
    .irq_lvl    (irq_lvl),
    .cur_mask   (cur_mask),
    .fault_vec  (fault_vec),
    .irq_take   (irq_take)
  );

  exc_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W)) frame_i (
    .sp         (sp_o),
    .sr_keep    (sr_copy),
    .vec        (vec_r),
    .pop_adj    (pop_adj),
    .frame_base (frame_base),
    .frame_word (frame_word),
    .sp_restore (sp_restore)
  );

  // request arbitration while idle: fault, then interrupt, then return
  always_comb begin
    go_entry  = 1'b0;
    go_irq    = 1'b0;
    go_pop    = 1'b0;
    entry_vec = fault_vec;
    if (fault_req) begin
      go_entry = 1'b1;
    end else if (irq_take) begin
      go_irq = 1'b1;
    end else if (rte_req) begin
      if (sr_o[SR_SUPER]) begin
        go_pop = 1'b1;
      end else begin
        go_entry  = 1'b1;
        entry_vec = VEC_W'(VEC_PRIV);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_BOOT_SP;
      sr_o      <= SR_RESET;
      vbr_o     <= '0;
      sp_o      <= '0;
      pc_o      <= '0;
      vec_r     <= '0;
      sr_copy   <= '0;
      pc_save   <= '0;
      pop_sr    <= '0;
      pop_adj   <= '0;
      iack_req  <= 1'b0;
      iack_lvl  <= '0;
      mem_req   <= 1'b1;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      busy      <= 1'b1;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (vbr_wr_en) vbr_o <= {vbr_wr_data[ADDR_W-1:2], 2'b00};

      case (state)
        ST_BOOT_SP: if (mem_rdy) begin
          sp_o     <= ADDR_W'(mem_rdata);
          mem_addr <= WORD_BYTES;
          state    <= ST_BOOT_PC;
        end

        ST_BOOT_PC: if (mem_rdy) begin
          pc_o    <= mem_rdata;
          mem_req <= 1'b0;
          busy    <= 1'b0;
          done    <= 1'b1;
          state   <= ST_IDLE;
        end

        ST_IDLE: begin
          if (go_entry) begin
            sr_copy   <= sr_o;
            sr_o      <= entry_sr(sr_o, cur_mask);
            vec_r     <= entry_vec;
            pc_save   <= ret_pc;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= frame_base + WORD_BYTES;
            mem_wdata <= DATA_W'(ret_pc);
            busy      <= 1'b1;
            state     <= ST_PUSH_PC;
          end else if (go_irq) begin
            sr_copy  <= sr_o;
            sr_o     <= entry_sr(sr_o, irq_lvl);
            pc_save  <= ret_pc;
            iack_req <= 1'b1;
            iack_lvl <= irq_lvl;
            busy     <= 1'b1;
            state    <= ST_IACK;
          end else if (go_pop) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= sp_o;
            busy     <= 1'b1;
            state    <= ST_RTE_SR;
          end
        end

        ST_IACK: if (iack_ack) begin
          iack_req  <= 1'b0;
          vec_r     <= iack_vec;
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= frame_base + WORD_BYTES;
          mem_wdata <= DATA_W'(pc_save);
          state     <= ST_PUSH_PC;
        end

        ST_PUSH_PC: if (mem_rdy) begin
          mem_addr  <= frame_base;
          mem_wdata <= frame_word;
          state     <= ST_PUSH_SR;
        end

        ST_PUSH_SR: if (mem_rdy) begin
          sp_o     <= frame_base;
          mem_we   <= 1'b0;
          mem_addr <= vbr_o + {{(ADDR_W-VEC_W-2){1'b0}}, vec_r, 2'b00};
          state    <= ST_FETCH;
        end

        ST_FETCH: if (mem_rdy) begin
          pc_o    <= mem_rdata;
          mem_req <= 1'b0;
          busy    <= 1'b0;
          done    <= 1'b1;
          state   <= ST_IDLE;
        end

        ST_RTE_SR: if (mem_rdy) begin
          pop_sr   <= mem_rdata[SR_W-1:0];
          pop_adj  <= mem_rdata[FMT_LO +: 2];
          mem_addr <= sp_o + WORD_BYTES;
          state    <= ST_RTE_PC;
        end

        ST_RTE_PC: if (mem_rdy) begin
          pc_o    <= mem_rdata;
          sr_o    <= pop_sr;
          sp_o    <= sp_restore;
          mem_req <= 1'b0;
          busy    <= 1'b0;
          done    <= 1'b1;
          state   <= ST_IDLE;
        end

        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_rdy,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              iack_req,
  input logic [15:0]       sr_o,
  input logic [ADDR_W-1:0] vbr_o,
  input logic              busy,
  input logic              done
);

  // R1: the cycle after reset shows the start-up state and the first read
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (sr_o == 16'h2700 && vbr_o == '0 && mem_req && !mem_we && mem_addr == '0));

  // R11: a stalled request is held unchanged
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R11: longword addresses only
  a_r11_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R3: acknowledge happens with supervisor on and trace off
  a_r3_super_in_iack: assert property (@(posedge clk) disable iff (rst)
    iack_req |-> (sr_o[13] && !sr_o[15] && !sr_o[12]));

  // R7: the completion pulse comes with the port idle
  a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !mem_req && !iack_req));

  // R10: a sequence in progress ends only with a done pulse
  a_r10_end_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R11: writes are only issued as part of a request
  a_r11_we_in_req: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req);

endmodule

bind exc_seq exc_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/exc_seq_tb_top.sv
module exc_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fault_req = 1'b0;
  logic [2:0]  fault_kind = '0;
  logic [3:0]  trap_idx = '0;
  logic        irq_req = 1'b0;
  logic [2:0]  irq_lvl = '0;
  logic        rte_req = 1'b0;
  logic [31:0] ret_pc = '0;
  logic        iack_req;
  logic [2:0]  iack_lvl;
  logic        iack_ack = 1'b0;
  logic [7:0]  iack_vec = '0;
  logic        vbr_wr_en = 1'b0;
  logic [31:0] vbr_wr_data = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rdy = 1'b0;
  logic [15:0] sr_o;
  logic [31:0] sp_o, pc_o, vbr_o;
  logic        busy, done;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [31:0] mem [256];
  logic [7:0]  irq_vec_v = 8'd64;

  logic [15:0] m_sr;
  logic [31:0] m_sp, m_pc, m_vbr;
  int          depth;

  always #5 clk = ~clk;

  exc_seq dut_i (.*);

  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk)
    if (mem_req && mem_rdy && mem_we) mem[mem_addr[9:2]] <= mem_wdata;

  always @(negedge clk) begin
    mem_rdy  = ($urandom % 4) != 0;
    iack_ack = iack_req && ($urandom % 2 == 0);
    iack_vec = irq_vec_v;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] fvec(input logic [2:0] k, input logic [3:0] t);
    case (k)
      3'd0: return 8'd2;
      3'd1: return 8'd4;
      3'd2: return 8'd5;
      3'd3: return 8'd8;
      3'd4: return 8'd32 + {4'd0, t};
      default: return 8'd4;
    endcase
  endfunction

  function automatic logic [15:0] esr(input logic [15:0] s, input logic [2:0] m);
    return (s & 16'h48FF) | 16'h2000 | {5'd0, m, 8'd0};
  endfunction

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem[a[9:2]];
  endfunction

  task automatic wait_done();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (done) return;
    end
    chk("done-timeout", 32'd0, 32'd1);
  endtask

  task automatic wait_busy();
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (busy) return;
    end
    chk("busy-timeout", 32'd0, 32'd1);
  endtask

  task automatic expect_entry(input logic [7:0] v, input logic [2:0] mask,
                              input logic [31:0] rpc, input string tag);
    logic [31:0] base, w0;
    base = {m_sp[31:2], 2'b00} - 32'd8;
    w0 = {4'd4 + {2'b00, m_sp[1:0]}, 2'b00, v, 2'b00, m_sr};
    wait_done();
    chk({tag, " R6 frame word"}, rd(base), w0);
    chk({tag, " R5 pushed pc"}, rd(base + 4), rpc);
    chk({tag, " R5 sp"}, sp_o, base);
    chk({tag, " R3 sr"}, {16'd0, sr_o}, {16'd0, esr(m_sr, mask)});
    chk({tag, " R7 handler pc"}, pc_o, rd(m_vbr + {22'd0, v, 2'b00}));
    m_sr = esr(m_sr, mask);
    m_sp = base;
    m_pc = pc_o;
    depth++;
  endtask

  task automatic do_fault(input logic [2:0] k, input logic [3:0] t,
                          input logic [31:0] rpc, input bit hold);
    @(negedge clk);
    fault_req = 1'b1; fault_kind = k; trap_idx = t; ret_pc = rpc;
    wait_busy();
    if (!hold) fault_req = 1'b0;
    expect_entry(fvec(k, t), m_sr[10:8], rpc, "fault");
    fault_req = 1'b0;
  endtask

  task automatic do_irq(input logic [2:0] l, input logic [7:0] v, input logic [31:0] rpc);
    logic [31:0] sp0;
    sp0 = m_sp;
    @(negedge clk);
    irq_req = 1'b1; irq_lvl = l; irq_vec_v = v; ret_pc = rpc;
    if (l > m_sr[10:8]) begin
      wait_busy();
      irq_req = 1'b0;
      expect_entry(v, l, rpc, "irq R4");
    end else begin
      repeat (12) @(negedge clk);
      chk("R4 masked irq busy", {31'd0, busy}, 32'd0);
      chk("R4 masked irq sp", sp_o, sp0);
      irq_req = 1'b0;
    end
  endtask

  task automatic do_rte(input logic [31:0] rpc);
    logic [31:0] w, epc;
    @(negedge clk);
    rte_req = 1'b1; ret_pc = rpc;
    if (m_sr[13]) begin
      w = rd(m_sp);
      epc = rd(m_sp + 4);
      wait_busy();
      rte_req = 1'b0;
      wait_done();
      chk("R8 rte sr", {16'd0, sr_o}, {16'd0, w[15:0]});
      chk("R8 rte pc", pc_o, epc);
      chk("R8 rte sp", sp_o, m_sp + 32'd8 + {30'd0, w[29:28]});
      m_sr = w[15:0]; m_pc = epc; m_sp = m_sp + 32'd8 + {30'd0, w[29:28]};
      depth--;
    end else begin
      wait_busy();
      rte_req = 1'b0;
      expect_entry(8'd8, m_sr[10:8], rpc, "R9 user rte");
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset sr", {16'd0, sr_o}, 32'h2700);
    chk("R1 reset vbr", vbr_o, 32'd0);
    chk("R1 reset done low", {31'd0, done}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    wait_done();
    chk("R1 boot sp", sp_o, mem[0]);
    chk("R1 boot pc", pc_o, mem[1]);
    chk("R1 boot sr", {16'd0, sr_o}, 32'h2700);
    m_sr = 16'h2700; m_sp = mem[0]; m_pc = mem[1]; m_vbr = 32'd0; depth = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem[i] = 32'h0001_0000 + i * 16;
    mem[0] = 32'h0000_03F3;
    mem[1] = 32'h0000_1000;

    do_reset();

    // misaligned start pointer: frame with format 7, then exact restore
    do_fault(3'd4, 4'd5, 32'h0000_2000, 1'b0);
    chk("R6 format nibble", {28'd0, rd(m_sp)[31:28]}, 32'd7);
    do_rte(32'h0);
    chk("R8 sp restored exactly", sp_o, 32'h0000_03F3);

    // R12 vector base write clears low bits
    @(negedge clk);
    vbr_wr_en = 1'b1; vbr_wr_data = 32'h0000_0103;
    @(negedge clk);
    vbr_wr_en = 1'b0;
    chk("R12 vbr value", vbr_o, 32'h0000_0100);
    m_vbr = 32'h0000_0100;

    // R10 request held through the sequence starts only one entry
    do_fault(3'd2, 4'd0, 32'h0000_2100, 1'b1);
    repeat (10) @(negedge clk);
    chk("R10 held request no second entry", sp_o, m_sp);

    // drop into user state with mask 0 by editing the saved frame
    mem[m_sp[9:2]] = {rd(m_sp)[31:16], 16'h0000};
    do_rte(32'h0);
    chk("R8 user sr", {16'd0, sr_o}, 32'd0);
    do_rte(32'h0000_2200);

    // R10 fault and interrupt together: fault first, interrupt next
    @(negedge clk);
    fault_req = 1'b1; fault_kind = 3'd2; ret_pc = 32'h0000_2300;
    irq_req = 1'b1; irq_lvl = 3'd5; irq_vec_v = 8'd83;
    wait_busy();
    fault_req = 1'b0;
    expect_entry(8'd5, m_sr[10:8], 32'h0000_2300, "R10 fault first");
    wait_busy();
    irq_req = 1'b0;
    expect_entry(8'd83, 3'd5, 32'h0000_2300, "R10 irq second");
    chk("R4 mask loaded", {29'd0, sr_o[10:8]}, 32'd5);

    do_irq(3'd5, 8'd90, 32'h0000_2400);
    do_irq(3'd3, 8'd90, 32'h0000_2400);
    do_irq(3'd6, 8'd91, 32'h0000_2500);

    // R2 reset in the middle of an entry
    @(negedge clk);
    fault_req = 1'b1; fault_kind = 3'd1; ret_pc = 32'h0000_2600;
    wait_busy();
    fault_req = 1'b0;
    @(negedge clk);
    do_reset();
    chk("R2 sp after abort", sp_o, 32'h0000_03F3);

    @(negedge clk);
    vbr_wr_en = 1'b1; vbr_wr_data = 32'h0000_0100;
    @(negedge clk);
    vbr_wr_en = 1'b0;
    m_vbr = 32'h0000_0100;

    // mixed random traffic
    for (int n = 0; n < 40; n++) begin
      int op;
      op = $urandom % 3;
      if (op == 2 && depth > 0) do_rte(32'h0);
      else if (op == 1 && depth < 8)
        do_irq(3'($urandom % 8), 8'(64 + $urandom % 32), 32'h0000_3000 + n * 4);
      else if (depth < 8)
        do_fault(3'($urandom % 8), 4'($urandom % 16), 32'h0000_4000 + n * 4, 1'b0);
      else do_rte(32'h0);
    end

    finish_run();
  end

endmodule